// File: doc/BRIEF.md
# Receive-Level Flow Controller with Automatic RTS

This block sits beside a UART's two 64-character FIFOs and turns their fill counts into flow-control decisions. It compares the receive fill count and the transmit free space against programmable thresholds. From those comparisons it raises a receive trigger and a transmit trigger, and it drives the RTS line with hysteresis so that the far end stops sending before the receive FIFO overflows.

Thresholds arrive as configuration bytes. A flow byte carries two 4-bit codes, halt in bits 3:0 and resume in bits 7:4. A level byte carries two 4-bit codes, TX trigger in bits 3:0 and RX trigger in bits 7:4. Every code counts in steps of four characters. When a trigger code is zero, the 2-bit trigger selection of the FIFO control byte applies to that direction instead. An enable byte switches automatic RTS on with bit 6 and automatic CTS on with bit 7. With automatic CTS on, a high CTS input holds off the start of the next transmit character. A character already on the line is not affected, because only the start permission is gated.

All three flag outputs are registered and follow their inputs one clock later. The CTS input passes through a two-stage synchronizer before it can gate the transmitter. Nothing checks that halt is above resume. If halt is programmed at or below resume, halt wins.

Top module: `afc_flow_ctrl`

## Requirements
- R1: While reset is asserted and right after it, rts_n is 0, rx_trig is 0, tx_trig is 0 and tx_start_ok is 1.
- R2: When lvl_cfg[7:4] is nonzero, the RX threshold is that code times 4. rx_trig equals (rx_fill >= threshold) one clock after the inputs.
- R3: When lvl_cfg[7:4] is zero, the RX threshold follows fifo_cfg[7:6]: 00 gives 8, 01 gives 16, 10 gives 56 and 11 gives 60. Those fifo_cfg bits are ignored when the code is nonzero.
- R4: The TX free space is 64 minus tx_fill. When lvl_cfg[3:0] is nonzero, the TX threshold is that code times 4, and tx_trig equals (free >= threshold) one clock later.
- R5: When lvl_cfg[3:0] is zero, the TX threshold follows fifo_cfg[5:4]: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 56. Those fifo_cfg bits are ignored when the code is nonzero.
- R6: With en_cfg[6]=1, rts_n goes to 1 one clock after rx_fill reaches flow_cfg[3:0]*4 or more.
- R7: With en_cfg[6]=1, rts_n keeps its value while rx_fill lies strictly between flow_cfg[7:4]*4 and flow_cfg[3:0]*4. It returns to 0 one clock after rx_fill falls to flow_cfg[7:4]*4 or below.
- R8: With en_cfg[6]=0, rts_n is 0 one clock later, whatever the fill count.
- R9: With en_cfg[7]=1, a high cts_n makes tx_start_ok 0 after two clock edges, not after one. tx_start_ok returns to 1 two edges after cts_n goes low.
- R10: With en_cfg[7]=0, tx_start_ok is 1 and cts_n has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_fill | input | 7 | Characters held in the receive FIFO (0 to 64) |
| tx_fill | input | 7 | Characters held in the transmit FIFO (0 to 64) |
| flow_cfg | input | 8 | Halt code [3:0], resume code [7:4], units of 4 |
| lvl_cfg | input | 8 | TX trigger code [3:0], RX trigger code [7:4], 0 selects fallback |
| fifo_cfg | input | 8 | Fallback RX select [7:6], fallback TX select [5:4] |
| en_cfg | input | 8 | Automatic RTS [6], automatic CTS [7] |
| cts_n | input | 1 | Clear-to-send from the far end, high means stop |
| rts_n | output | 1 | Request-to-send, high asks the far end to stop |
| rx_trig | output | 1 | Receive fill at or above RX threshold |
| tx_trig | output | 1 | Transmit free space at or above TX threshold |
| tx_start_ok | output | 1 | Transmitter may start the next character |

## Verification
The RTS halt and the receive trigger can both change in the same cycle when one fill count crosses both thresholds at once. The vector table steps rx_fill in a single cycle from below both levels to 56 and to 60, which are above a halt of 48 and at or above the fallback trigger. The bench then requires rts_n and rx_trig to be high in the same sample. It also steps the count back into the hysteresis band while the trigger drops, and there it expects rts_n held and rx_trig low in the same cycle.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int STEP       = 4;

  // Fallback receive threshold from the 2-bit selection
  function automatic int rx_fallback(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 56;
      default: return 60;
    endcase
  endfunction

  // Fallback transmit threshold from the 2-bit selection
  function automatic int tx_fallback(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 56;
    endcase
  endfunction
endpackage

// File: rtl/afc_level_sel.sv
module afc_level_sel #(
  parameter int CNT_W = 7,
  parameter int STEP  = 4,
  parameter bit IS_RX = 1'b1
) (
  input  logic [3:0]       code,
  input  logic [1:0]       fb_sel,
  output logic [CNT_W-1:0] level
);
  logic [CNT_W-1:0] fb_level;
  logic [CNT_W-1:0] code_level;

  generate
    if (IS_RX) begin : g_rx
      assign fb_level = CNT_W'(afc_pkg::rx_fallback(fb_sel));
    end else begin : g_tx
      assign fb_level = CNT_W'(afc_pkg::tx_fallback(fb_sel));
    end
  endgenerate

  assign code_level = CNT_W'(32'(code) * STEP);
  // a nonzero code overrides the fallback selection (R3, R5)
  assign level = (code != 4'd0) ? code_level : fb_level;
endmodule

// File: rtl/afc_rts_hyst.sv
module afc_rts_hyst #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] halt_lvl,
  input  logic [CNT_W-1:0] resume_lvl,
  output logic             rts_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rts_n <= 1'b0;
    else if (!en)               rts_n <= 1'b0;
    else if (fill >= halt_lvl)  rts_n <= 1'b1;
    else if (fill <= resume_lvl) rts_n <= 1'b0;
  end

  assert_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en) && ($past(fill) >= $past(halt_lvl))) |-> rts_n);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en) && ($past(fill) < $past(halt_lvl)) &&
     ($past(fill) > $past(resume_lvl))) |-> $stable(rts_n));

  assert_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en)) |-> !rts_n);
endmodule

// File: rtl/afc_cts_gate.sv
module afc_cts_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cts_n,
  output logic start_ok
);
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= (i == 0) ? cts_n : sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  // only the start of a character is gated; one in flight runs on
  assign start_ok = !(en && sync_q[SYNC_STAGES-1]);

  generate
    if (SYNC_STAGES == 2) begin : g_chk
      assert_cts_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && en && $past(cts_n, 2)) |-> !start_ok);
      assert_cts_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |-> start_ok);
    end
  endgenerate
endmodule

// File: rtl/afc_flow_ctrl.sv
module afc_flow_ctrl #(
  parameter int DEPTH       = afc_pkg::FIFO_DEPTH,
  parameter int STEP        = afc_pkg::STEP,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] rx_fill,
  input  logic [6:0] tx_fill,
  input  logic [7:0] flow_cfg,
  input  logic [7:0] lvl_cfg,
  input  logic [7:0] fifo_cfg,
  input  logic [7:0] en_cfg,
  input  logic       cts_n,
  output logic       rts_n,
  output logic       rx_trig,
  output logic       tx_trig,
  output logic       tx_start_ok
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] rx_lvl, tx_lvl, tx_free, halt_lvl, resume_lvl;
  logic             auto_rts, auto_cts;

  assign auto_rts   = en_cfg[6];
  assign auto_cts   = en_cfg[7];
  assign tx_free    = CNT_W'(DEPTH) - CNT_W'(tx_fill);
  assign halt_lvl   = CNT_W'(32'(flow_cfg[3:0]) * STEP);
  assign resume_lvl = CNT_W'(32'(flow_cfg[7:4]) * STEP);

  afc_level_sel #(.CNT_W(CNT_W), .STEP(STEP), .IS_RX(1'b1)) u_rx_sel (
    .code(lvl_cfg[7:4]), .fb_sel(fifo_cfg[7:6]), .level(rx_lvl));

  afc_level_sel #(.CNT_W(CNT_W), .STEP(STEP), .IS_RX(1'b0)) u_tx_sel (
    .code(lvl_cfg[3:0]), .fb_sel(fifo_cfg[5:4]), .level(tx_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_trig <= 1'b0;
      tx_trig <= 1'b0;
    end else begin
      rx_trig <= (CNT_W'(rx_fill) >= rx_lvl);
      tx_trig <= (tx_free >= tx_lvl);
    end
  end

  afc_rts_hyst #(.CNT_W(CNT_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .en(auto_rts), .fill(CNT_W'(rx_fill)),
    .halt_lvl(halt_lvl), .resume_lvl(resume_lvl), .rts_n(rts_n));

  afc_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst_n(rst_n), .en(auto_cts), .cts_n(cts_n),
    .start_ok(tx_start_ok));

  // R2 and R3: receive trigger tracks the selected threshold
  assert_rx_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rx_trig == (CNT_W'($past(rx_fill)) >= $past(rx_lvl))));

  // R4 and R5: transmit trigger tracks the selected threshold
  assert_tx_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (tx_trig == ($past(tx_free) >= $past(tx_lvl))));

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (!rts_n && !rx_trig && !tx_trig));
endmodule

// File: tb/afc_flow_ctrl_bench.sv
module afc_flow_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] rx_fill = '0, tx_fill = '0;
  logic [7:0] flow_cfg = '0, lvl_cfg = '0, fifo_cfg = '0, en_cfg = '0;
  logic       cts_n = 1'b0;
  logic       rts_n, rx_trig, tx_trig, tx_start_ok;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  afc_flow_ctrl u_afc_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .tx_fill(tx_fill),
    .flow_cfg(flow_cfg), .lvl_cfg(lvl_cfg), .fifo_cfg(fifo_cfg),
    .en_cfg(en_cfg), .cts_n(cts_n), .rts_n(rts_n), .rx_trig(rx_trig),
    .tx_trig(tx_trig), .tx_start_ok(tx_start_ok));

  // {rx_fill, tx_fill, flow, lvl, fifo, en, exp_rts, exp_rx, exp_tx}
  localparam int NV = 20;
  localparam logic [48:0] VECS [NV] = '{
    {7'd0,  7'd0,  8'h6C, 8'h00, 8'h00, 8'h40, 1'b0, 1'b0, 1'b1}, // R3 R5
    {7'd8,  7'd56, 8'h6C, 8'h00, 8'h00, 8'h40, 1'b0, 1'b1, 1'b1}, // R3 R5 at level
    {7'd7,  7'd57, 8'h6C, 8'h00, 8'h00, 8'h40, 1'b0, 1'b0, 1'b0}, // R3 R5 below
    {7'd15, 7'd0,  8'h6C, 8'h00, 8'h40, 8'h40, 1'b0, 1'b0, 1'b1}, // R3 sel 01
    {7'd56, 7'd48, 8'h6C, 8'h00, 8'h80, 8'h40, 1'b1, 1'b1, 1'b1}, // R6 + R3 same cycle
    {7'd40, 7'd48, 8'h6C, 8'h00, 8'h80, 8'h40, 1'b1, 1'b0, 1'b1}, // R7 hold high
    {7'd24, 7'd48, 8'h6C, 8'h00, 8'h80, 8'h40, 1'b0, 1'b0, 1'b1}, // R7 resume
    {7'd30, 7'd48, 8'h6C, 8'h00, 8'h80, 8'h40, 1'b0, 1'b0, 1'b1}, // R7 hold low
    {7'd60, 7'd48, 8'h6C, 8'h00, 8'hC0, 8'h40, 1'b1, 1'b1, 1'b1}, // R3 sel 11, R6
    {7'd20, 7'd8,  8'h6C, 8'h00, 8'h30, 8'h40, 1'b0, 1'b1, 1'b1}, // R5 sel 11
    {7'd20, 7'd9,  8'h6C, 8'h00, 8'h30, 8'h40, 1'b0, 1'b1, 1'b0}, // R5 below 56
    {7'd0,  7'd32, 8'h6C, 8'h00, 8'h20, 8'h40, 1'b0, 1'b0, 1'b1}, // R5 sel 10
    {7'd0,  7'd49, 8'h6C, 8'h00, 8'h10, 8'h40, 1'b0, 1'b0, 1'b0}, // R5 sel 01
    {7'd12, 7'd60, 8'h6C, 8'h31, 8'hF0, 8'h40, 1'b0, 1'b1, 1'b1}, // R2 R4 override
    {7'd11, 7'd61, 8'h6C, 8'h31, 8'hF0, 8'h40, 1'b0, 1'b0, 1'b0}, // R2 R4 below
    {7'd60, 7'd8,  8'h6C, 8'hF0, 8'hF0, 8'h40, 1'b1, 1'b1, 1'b1}, // R2 code F, R5
    {7'd60, 7'd8,  8'h6C, 8'hF0, 8'hF0, 8'h00, 1'b0, 1'b1, 1'b1}, // R8 disabled
    {7'd47, 7'd0,  8'h6C, 8'h00, 8'h00, 8'h40, 1'b0, 1'b1, 1'b1}, // R6 just below
    {7'd48, 7'd0,  8'h6C, 8'h00, 8'h00, 8'h40, 1'b1, 1'b1, 1'b1}, // R6 at halt
    {7'd25, 7'd0,  8'h6C, 8'h00, 8'h00, 8'hC0, 1'b1, 1'b1, 1'b1}  // R7 hold above
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "rts_n", rts_n, 1'b0);
    chk("R1", "rx_trig", rx_trig, 1'b0);
    chk("R1", "tx_trig", tx_trig, 1'b0);
    chk("R1", "tx_start_ok", tx_start_ok, 1'b1);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      v = VECS[i];
      rx_fill = v[48:42]; tx_fill = v[41:35]; flow_cfg = v[34:27];
      lvl_cfg = v[26:19]; fifo_cfg = v[18:11]; en_cfg = v[10:3];
      step();
      chk($sformatf("vec%0d R6/R7/R8", i), "rts_n", rts_n, v[2]);
      chk($sformatf("vec%0d R2/R3", i), "rx_trig", rx_trig, v[1]);
      chk($sformatf("vec%0d R4/R5", i), "tx_trig", tx_trig, v[0]);
    end

    // R9: automatic CTS, two-edge synchronizer latency
    en_cfg = 8'h80; cts_n = 1'b0;
    step(); step();
    chk("R9", "ok idle", tx_start_ok, 1'b1);
    cts_n = 1'b1;
    step();
    chk("R9", "ok after one edge", tx_start_ok, 1'b1);
    step();
    chk("R9", "ok after two edges", tx_start_ok, 1'b0);
    cts_n = 1'b0;
    step();
    chk("R9", "still held one edge", tx_start_ok, 1'b0);
    step();
    chk("R9", "released", tx_start_ok, 1'b1);

    // R10: CTS ignored when automatic CTS is off
    en_cfg = 8'h00; cts_n = 1'b1;
    step(); step(); step();
    chk("R10", "ok with cts high", tx_start_ok, 1'b1);
    en_cfg = 8'h80;
    #1;
    chk("R9", "enable with cts already high", tx_start_ok, 1'b0);

    // R1: reset while halted clears every flag
    en_cfg = 8'h40; flow_cfg = 8'h6C; lvl_cfg = 8'h00; fifo_cfg = 8'h00;
    rx_fill = 7'd60; tx_fill = 7'd0;
    step();
    chk("R6", "halt before reset", rts_n, 1'b1);
    rst_n = 1'b0;
    #2;
    chk("R1", "rts_n in reset", rts_n, 1'b0);
    chk("R1", "rx_trig in reset", rx_trig, 1'b0);
    chk("R1", "tx_trig in reset", tx_trig, 1'b0);
    chk("R1", "ok in reset", tx_start_ok, 1'b1);
    step();
    rst_n = 1'b1;
    step();
    chk("R6", "halt again after reset", rts_n, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule